// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block sits behind a CAN receiver and decides, for each received frame, whether its identifier is wanted. The receiver presents the four identifier bytes of the frame together with a one-cycle valid strobe. The block compares those bytes against eight programmable code bytes and eight don't-care mask bytes. One cycle later it raises an accept strobe and a receive-flag set pulse, and it reports the number of the filter that matched.

The sixteen configuration bytes form two banks of four. A mode select turns them into one of four filter layouts: two full-width filters, four half-width filters, eight single-byte filters, or a closed state in which nothing passes. The mode and the bytes can only be changed while the init input is high. During init, received identifiers are ignored.

The control is a three-state machine. `ST_CONFIG` is entered whenever init is high. `ST_LISTEN` waits for an identifier. `ST_REPORT` is the one-cycle result state. The transitions are:
- any state goes to `ST_CONFIG` when init is high;
- any state goes to `ST_REPORT` when init is low, valid is high and at least one filter hits;
- any state goes to `ST_LISTEN` when init is low and there is no valid hit.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, all code and mask bytes are zero, the mode is closed, and `accept_o`, `rxf_set_o` and `hit_idx_o` are all zero.
- R2: A mask bit of 1 makes the matching identifier bit don't-care. A mask bit of 0 requires the identifier bit to equal the code bit. Identifier byte j is `id_i[31-8j -: 8]`, so byte 0 is bits 31:24.
- R3: In mode 0 (two wide filters), filter b (b = 0 or 1) hits when every identifier byte j (0..3) matches code byte 4b+j under mask byte 4b+j.
- R4: In mode 1 (four half-width filters), filter f (0..3) hits when identifier byte 0 matches code byte 2f and identifier byte 1 matches code byte 2f+1. Identifier bytes 2 and 3 have no effect.
- R5: In mode 2 (eight byte filters), filter f (0..7) hits when identifier byte 0 matches code byte f. Bytes 1 to 3 have no effect.
- R6: In mode 3 (closed), no identifier is ever accepted and `rxf_set_o` never pulses.
- R7: When several filters hit, `hit_idx_o` reports the lowest-numbered one.
- R8: When `id_valid_i` is sampled high with init low and some filter hits, `accept_o` and `rxf_set_o` are both high during the following cycle only, and `hit_idx_o` then holds the filter number. In every other cycle all three outputs are zero.
- R9: Configuration writes (`cfg_we_i`) and the mode input take effect only while `init_i` is high. Outside init they leave filtering unchanged.
- R10: While `init_i` is high, `id_valid_i` is ignored and no accept is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Configuration window; enables writes and mode capture, blocks filtering |
| mode_i | input | 2 | Filter layout: 0 wide, 1 half, 2 byte, 3 closed |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_mask_i | input | 1 | 1 selects a mask byte, 0 a code byte |
| cfg_idx_i | input | 3 | Byte number 0..7 (0..3 bank 0, 4..7 bank 1) |
| cfg_data_i | input | 8 | Byte value to write |
| id_valid_i | input | 1 | One-cycle strobe: identifier bytes are present |
| id_i | input | 32 | Identifier bytes, byte 0 in bits 31:24 |
| accept_o | output | 1 | One-cycle accept strobe |
| hit_idx_o | output | 3 | Lowest hitting filter number while accepted |
| rxf_set_o | output | 1 | One-cycle receive-flag set pulse |

## Verification
The hardest case to reach is one where several filters hit at once and the priority rule alone decides the reported number. The same applies to a write or mode change issued outside init that would have changed the outcome had it landed. The stimulus creates the first by configuring a bank with all-ones masks, so that it overlaps exact-match filters, and then sends identifiers that hit both. It creates the second by writing a code byte with init low and then sending one identifier that only the old value accepts and one that only the new value would accept. Back-to-back valid strobes check that consecutive result cycles stay separate.

// File: rtl/can_af_pkg.sv
package can_af_pkg;

    localparam int BANK_BYTES = 4;

    typedef enum logic [1:0] {
        MODE_W32    = 2'd0,
        MODE_W16    = 2'd1,
        MODE_W8     = 2'd2,
        MODE_CLOSED = 2'd3
    } fmode_e;

    typedef enum logic [1:0] {
        ST_CONFIG = 2'd0,
        ST_LISTEN = 2'd1,
        ST_REPORT = 2'd2
    } fsm_e;

endpackage

// File: rtl/can_af_regs.sv
// Configuration store: code/mask bytes and mode, writable only in init (R9).
module can_af_regs
    import can_af_pkg::*;
#(
    parameter int NUM_BYTES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   init_i,
    input  logic [1:0]             mode_i,
    input  logic                   cfg_we_i,
    input  logic                   cfg_mask_i,
    input  logic [IDX_W-1:0]       cfg_idx_i,
    input  logic [7:0]             cfg_data_i,
    output fmode_e                 mode_o,
    output logic [NUM_BYTES*8-1:0] code_o,
    output logic [NUM_BYTES*8-1:0] mask_o
);

    logic wr_ok;
    assign wr_ok = cfg_we_i && init_i;

    // R1: reset mode is closed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o <= MODE_CLOSED;
        end else if (init_i) begin
            mode_o <= fmode_e'(mode_i);
        end
    end

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        logic [7:0] code_q;
        logic [7:0] mask_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q <= 8'h00;
                mask_q <= 8'h00;
            end else if (wr_ok && (cfg_idx_i == IDX_W'(i))) begin
                if (cfg_mask_i) begin
                    mask_q <= cfg_data_i;
                end else begin
                    code_q <= cfg_data_i;
                end
            end
        end

        assign code_o[8*i +: 8] = code_q;
        assign mask_o[8*i +: 8] = mask_q;
    end

endmodule

// File: rtl/can_af_match.sv
// Comparator matrix and per-mode hit selection (R2..R6).
module can_af_match
    import can_af_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int NUM_BYTES = NUM_BANKS * BANK_BYTES,
    localparam int NUM_HALF  = NUM_BANKS * 2,
    localparam int NUM_FILT  = NUM_BYTES
) (
    input  fmode_e                 mode_i,
    input  logic [31:0]            id_i,
    input  logic [NUM_BYTES*8-1:0] code_i,
    input  logic [NUM_BYTES*8-1:0] mask_i,
    output logic [NUM_FILT-1:0]    hit_o
);

    logic [BANK_BYTES-1:0][7:0]            id_byte;
    logic [NUM_BYTES-1:0][BANK_BYTES-1:0]  eq;
    logic [NUM_BANKS-1:0]                  hit_w32;
    logic [NUM_HALF-1:0]                   hit_w16;
    logic [NUM_FILT-1:0]                   hit_w8;

    for (genvar j = 0; j < BANK_BYTES; j++) begin : g_idb
        assign id_byte[j] = id_i[31-8*j -: 8];
    end

    // R2: masked equality of every code byte against every id byte
    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_row
        for (genvar j = 0; j < BANK_BYTES; j++) begin : g_col
            assign eq[i][j] =
                ((id_byte[j] ^ code_i[8*i +: 8]) & ~mask_i[8*i +: 8]) == 8'h00;
        end
    end

    // R3: wide filters, one per bank
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_w32
        assign hit_w32[b] = eq[4*b][0] && eq[4*b+1][1] &&
                            eq[4*b+2][2] && eq[4*b+3][3];
    end

    // R4: half-width filters, two per bank
    for (genvar f = 0; f < NUM_HALF; f++) begin : g_w16
        assign hit_w16[f] = eq[2*f][0] && eq[2*f+1][1];
    end

    // R5: byte filters, four per bank
    for (genvar f = 0; f < NUM_FILT; f++) begin : g_w8
        assign hit_w8[f] = eq[f][0];
    end

    always_comb begin
        hit_o = '0;
        unique case (mode_i)
            MODE_W32:    hit_o[NUM_BANKS-1:0] = hit_w32;
            MODE_W16:    hit_o[NUM_HALF-1:0]  = hit_w16;
            MODE_W8:     hit_o                = hit_w8;
            MODE_CLOSED: hit_o                = '0;  // R6
            default:     hit_o                = '0;
        endcase
    end

endmodule

// File: rtl/can_af_ctrl.sv
// Result state machine with lowest-index priority (R7, R8, R10).
module can_af_ctrl
    import can_af_pkg::*;
#(
    parameter int NUM_FILT = 8,
    localparam int IDX_W = $clog2(NUM_FILT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                init_i,
    input  logic                id_valid_i,
    input  logic [NUM_FILT-1:0] hit_i,
    output logic                accept_o,
    output logic                rxf_set_o,
    output logic [IDX_W-1:0]    hit_idx_o,
    output fsm_e                state_o
);

    fsm_e             state;
    fsm_e             state_nx;
    logic [IDX_W-1:0] enc;
    logic [IDX_W-1:0] idx_q;
    logic             any_hit;
    logic             take;

    // R7: lowest-numbered hit wins
    always_comb begin
        enc = '0;
        for (int f = NUM_FILT - 1; f >= 0; f--) begin
            if (hit_i[f]) begin
                enc = IDX_W'(f);
            end
        end
    end

    assign any_hit = |hit_i;
    assign take    = id_valid_i && any_hit;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CONFIG: begin
                if (init_i)    state_nx = ST_CONFIG;   // R10
                else if (take) state_nx = ST_REPORT;
                else           state_nx = ST_LISTEN;
            end
            ST_LISTEN: begin
                if (init_i)    state_nx = ST_CONFIG;
                else if (take) state_nx = ST_REPORT;
                else           state_nx = ST_LISTEN;
            end
            ST_REPORT: begin
                if (init_i)    state_nx = ST_CONFIG;
                else if (take) state_nx = ST_REPORT;
                else           state_nx = ST_LISTEN;
            end
            default:           state_nx = ST_CONFIG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CONFIG;
            idx_q <= '0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_REPORT) begin
                idx_q <= enc;
            end
        end
    end

    // R8: outputs decoded from the state
    always_comb begin
        accept_o  = 1'b0;
        rxf_set_o = 1'b0;
        hit_idx_o = '0;
        unique case (state)
            ST_CONFIG: ;
            ST_LISTEN: ;
            ST_REPORT: begin
                accept_o  = 1'b1;
                rxf_set_o = 1'b1;
                hit_idx_o = idx_q;
            end
            default: ;
        endcase
    end

    assign state_o = state;

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_af_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int NUM_BYTES = NUM_BANKS * BANK_BYTES,
    localparam int IDX_W     = $clog2(NUM_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic [1:0]       mode_i,
    input  logic             cfg_we_i,
    input  logic             cfg_mask_i,
    input  logic [IDX_W-1:0] cfg_idx_i,
    input  logic [7:0]       cfg_data_i,
    input  logic             id_valid_i,
    input  logic [31:0]      id_i,
    output logic             accept_o,
    output logic [IDX_W-1:0] hit_idx_o,
    output logic             rxf_set_o
);

    fmode_e                 cur_mode;
    fsm_e                   state;
    logic [NUM_BYTES*8-1:0] code_flat;
    logic [NUM_BYTES*8-1:0] mask_flat;
    logic [NUM_BYTES-1:0]   hit_vec;

    can_af_regs #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .mode_i     (mode_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_mask_i (cfg_mask_i),
        .cfg_idx_i  (cfg_idx_i),
        .cfg_data_i (cfg_data_i),
        .mode_o     (cur_mode),
        .code_o     (code_flat),
        .mask_o     (mask_flat)
    );

    can_af_match #(.NUM_BANKS(NUM_BANKS)) u_match (
        .mode_i (cur_mode),
        .id_i   (id_i),
        .code_i (code_flat),
        .mask_i (mask_flat),
        .hit_o  (hit_vec)
    );

    can_af_ctrl #(.NUM_FILT(NUM_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .id_valid_i (id_valid_i),
        .hit_i      (hit_vec),
        .accept_o   (accept_o),
        .rxf_set_o  (rxf_set_o),
        .hit_idx_o  (hit_idx_o),
        .state_o    (state)
    );

endmodule

// File: rtl/can_af_checker.sv
module can_af_checker
    import can_af_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_i,
    input logic             id_valid_i,
    input logic             accept_o,
    input logic             rxf_set_o,
    input logic [IDX_W-1:0] hit_idx_o,
    input fmode_e           cur_mode
);

    a_r8_accept_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(id_valid_i && !init_i));

    a_r8_idx_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !accept_o |-> (hit_idx_o == '0));

    a_r6_closed_never_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o || rxf_set_o) |-> (cur_mode != MODE_CLOSED));

    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> $stable(cur_mode));

    a_r10_init_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> !accept_o);

    a_r3_wide_index: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && cur_mode == MODE_W32) |-> (hit_idx_o < IDX_W'(2)));

endmodule

bind can_accept_filter can_af_checker #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_i     (init_i),
    .id_valid_i (id_valid_i),
    .accept_o   (accept_o),
    .rxf_set_o  (rxf_set_o),
    .hit_idx_o  (hit_idx_o),
    .cur_mode   (cur_mode)
);

// File: tb/tb_can_accept_filter.sv
`timescale 1ns/1ps
module tb_can_accept_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0;
    logic [1:0]  mode_i = 2'd3;
    logic        cfg_we_i = 1'b0;
    logic        cfg_mask_i = 1'b0;
    logic [2:0]  cfg_idx_i = 3'd0;
    logic [7:0]  cfg_data_i = 8'h00;
    logic        id_valid_i = 1'b0;
    logic [31:0] id_i = 32'h0;
    logic        accept_o;
    logic [2:0]  hit_idx_o;
    logic        rxf_set_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    can_accept_filter dut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .mode_i(mode_i),
        .cfg_we_i(cfg_we_i), .cfg_mask_i(cfg_mask_i), .cfg_idx_i(cfg_idx_i),
        .cfg_data_i(cfg_data_i), .id_valid_i(id_valid_i), .id_i(id_i),
        .accept_o(accept_o), .hit_idx_o(hit_idx_o), .rxf_set_o(rxf_set_o)
    );

    // reference configuration model
    logic [7:0] bcode [8];
    logic [7:0] bmask [8];
    int         bmode = 3;

    typedef struct {
        int    hit;
        string req;
    } exp_t;
    exp_t sbq[$];

    function automatic bit bok(logic [7:0] idb, logic [7:0] c, logic [7:0] m);
        return ((idb ^ c) & ~m) == 8'h00;
    endfunction

    function automatic int ref_hit(logic [31:0] id);
        logic [7:0] b [4];
        for (int j = 0; j < 4; j++) b[j] = id[31-8*j -: 8];
        case (bmode)
            0: for (int k = 0; k < 2; k++)
                   if (bok(b[0], bcode[4*k], bmask[4*k]) && bok(b[1], bcode[4*k+1], bmask[4*k+1]) &&
                       bok(b[2], bcode[4*k+2], bmask[4*k+2]) && bok(b[3], bcode[4*k+3], bmask[4*k+3]))
                       return k;
            1: for (int f = 0; f < 4; f++)
                   if (bok(b[0], bcode[2*f], bmask[2*f]) && bok(b[1], bcode[2*f+1], bmask[2*f+1]))
                       return f;
            2: for (int f = 0; f < 8; f++)
                   if (bok(b[0], bcode[f], bmask[f])) return f;
            default: return -1;
        endcase
        return -1;
    endfunction

    // scoreboard monitor
    logic vprev = 1'b0;
    always @(posedge clk) vprev <= rst_n && id_valid_i && !init_i;

    always @(negedge clk) begin
        if (rst_n) begin
            if (vprev) begin
                exp_t e;
                int   ea;
                e = sbq.pop_front();
                ea = (e.hit >= 0) ? 1 : 0;
                checks++;
                if (accept_o !== ea[0] || rxf_set_o !== ea[0] ||
                    (ea == 1 && int'(hit_idx_o) != e.hit) || (ea == 0 && hit_idx_o != 3'd0)) begin
                    errors++;
                    $display("FAIL %s: actual acc=%0b rxf=%0b idx=%0d expected acc=%0d idx=%0d",
                             e.req, accept_o, rxf_set_o, hit_idx_o, ea, (e.hit < 0) ? 0 : e.hit);
                end
            end else if (accept_o || rxf_set_o) begin
                checks++;
                errors++;
                $display("FAIL R8: actual acc=%0b rxf=%0b expected no pulse", accept_o, rxf_set_o);
            end
        end
    end

    task automatic send(input logic [31:0] id, input string req);
        exp_t e;
        id_i = id;
        id_valid_i = 1'b1;
        if (!init_i) begin
            e.hit = ref_hit(id);
            e.req = req;
            sbq.push_back(e);
        end
        @(negedge clk);
        id_valid_i = 1'b0;
    endtask

    task automatic wr(input bit msk, input int idx, input logic [7:0] d);
        cfg_we_i = 1'b1;
        cfg_mask_i = msk;
        cfg_idx_i = idx[2:0];
        cfg_data_i = d;
        if (init_i) begin
            if (msk) bmask[idx] = d; else bcode[idx] = d;
        end
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic enter_init(input int m);
        init_i = 1'b1;
        mode_i = m[1:0];
        bmode = m;
        @(negedge clk);
    endtask

    task automatic leave_init();
        init_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin bcode[i] = 8'h00; bmask[i] = 8'h00; end
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state
        checks++;
        if (accept_o !== 1'b0 || rxf_set_o !== 1'b0 || hit_idx_o !== 3'd0) begin
            errors++;
            $display("FAIL R1: actual acc=%0b rxf=%0b idx=%0d expected 0 0 0", accept_o, rxf_set_o, hit_idx_o);
        end
        send(32'h0000_0000, "R1");          // closed after reset, zero id
        send(32'h1234_5678, "R6");
        idle(2);

        // mode 0: two wide filters
        enter_init(0);
        wr(0, 0, 8'hA5); wr(0, 1, 8'h3C); wr(0, 2, 8'h12); wr(0, 3, 8'h7E);
        for (int i = 4; i < 8; i++) wr(1, i, 8'hFF);
        leave_init();
        send(32'hA53C_127E, "R7");          // both hit, 0 wins
        send(32'h0000_0000, "R3");          // only wildcard bank 1
        send(32'hA53C_127F, "R3");          // last byte differs
        idle(2);
        enter_init(0);
        wr(0, 4, 8'h11); wr(0, 5, 8'h22); wr(0, 6, 8'h33); wr(0, 7, 8'h44);
        for (int i = 4; i < 8; i++) wr(1, i, 8'h00);
        wr(1, 3, 8'h0F);
        leave_init();
        send(32'hA53C_1279, "R2");          // masked low nibble
        send(32'hA53C_126E, "R2");          // unmasked bit differs
        send(32'h1122_3344, "R3");
        send(32'hDEAD_BEEF, "R3");
        idle(2);

        // mode 1: four half-width filters
        enter_init(1);
        wr(0, 0, 8'h12); wr(0, 1, 8'h34); wr(0, 2, 8'h56); wr(0, 3, 8'h78);
        wr(0, 4, 8'h9A); wr(0, 5, 8'hBC); wr(0, 6, 8'hDE); wr(0, 7, 8'hF0);
        for (int i = 0; i < 8; i++) wr(1, i, 8'h00);
        wr(1, 7, 8'h0F);
        leave_init();
        send(32'h5678_AAAA, "R4");
        send(32'h5678_0000, "R4");          // bytes 2,3 no effect
        send(32'hDEF5_0000, "R4");
        send(32'h1234_FFFF, "R4");
        send(32'h1235_0000, "R4");
        send(32'h9ABC_1234, "R4");
        idle(2);

        // mode 2: eight byte filters
        enter_init(2);
        for (int i = 0; i < 8; i++) begin wr(0, i, 8'((i + 1) * 16)); wr(1, i, 8'h00); end
        wr(1, 2, 8'hFF);
        leave_init();
        send(32'h10FF_FFFF, "R5");
        send(32'h2000_0000, "R5");
        send(32'h8012_3456, "R7");          // f2 wildcard beats f7
        send(32'h5500_0000, "R5");
        idle(2);
        enter_init(2);
        wr(1, 2, 8'h00);
        leave_init();
        send(32'h8000_0000, "R5");
        send(32'h5500_0000, "R5");
        idle(2);

        // R9: writes and mode changes outside init are ignored
        wr(0, 0, 8'h99);
        mode_i = 2'd3;
        idle(2);
        send(32'h1000_0000, "R9");
        send(32'h9900_0000, "R9");
        idle(2);

        // R8: back-to-back identifiers
        send(32'h2000_0000, "R8");
        send(32'h1000_0000, "R8");
        send(32'h7000_0000, "R8");
        idle(2);

        // R10: valid during init ignored
        init_i = 1'b1;
        mode_i = 2'd2;
        send(32'h1000_0000, "R10");
        checks++;
        if (accept_o !== 1'b0) begin
            errors++;
            $display("FAIL R10: actual acc=%0b expected 0", accept_o);
        end
        leave_init();

        // R6: closed mode with all-wildcard masks
        enter_init(3);
        for (int i = 0; i < 8; i++) wr(1, i, 8'hFF);
        leave_init();
        send(32'h0000_0000, "R6");
        send(32'hFFFF_FFFF, "R6");
        idle(3);

        checks++;
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R8: actual %0d pending expected 0", sbq.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule